// File: doc/BRIEF.md
# DS3 Frame-Master Payload Source

This block is the terminal-side feeder of a serial DS3 payload stream. It sends one payload bit per bit-clock cycle toward a framer that shares the same clock. It also acts as the frame master: a start-of-frame strobe marks the first bit of every frame, and a free-running position counter sets the frame period.

Payload arrives as bytes over a ready/valid handshake and leaves most significant bit first. The framer raises an overhead indicator one bit period before it inserts an overhead bit. The block samples this indicator on each rising edge. When it is high, the block keeps the current bit on the line for one more cycle and takes no new bit. If a bit is due and no byte is waiting, a configurable fill bit is sent and a sticky underrun flag is raised.

Frame length is the product of three parameters: bits per block, blocks per subframe, and subframes per frame. The defaults give 85 × 8 × 7 = 4760 cycles. The frame counter can be built as one flat counter or as three nested counters.

Top module: `ds3_payload_source`

## Requirements
- R1: While `rst` is high, `ser_o`, `sof_o`, `src_ready_o` and `underrun_o` are all 0.
- R2: The first rising edge at which `rst` is sampled low launches a frame: `sof_o` is 1 in the cycle that follows, and 0 in the cycle after that.
- R3: After the first strobe, `sof_o` is high for exactly one cycle every FRAME_LEN cycles, where FRAME_LEN = BLOCK_BITS × BLOCKS_PER_SUB × SUBFRAMES.
- R4: Each accepted byte appears on `ser_o` over eight unstalled cycles, bit 7 first and bit 0 last. The first bit appears in the cycle after the accepting edge.
- R5: If `oh_ind_i` is sampled high at a rising edge outside reset, `ser_o` keeps its value through the next cycle and no payload bit is consumed.
- R6: `src_ready_o` is 1 only when `rst` is low, `oh_ind_i` is low and every bit of the previous byte has been sent. A byte transfers at a rising edge where `src_ready_o` and `src_valid_i` are both high.
- R7: At a rising edge where `src_ready_o` is high and `src_valid_i` is low, the next `ser_o` value is the parameter FILL_BIT and `underrun_o` becomes 1. `underrun_o` then stays 1 until reset.
- R8: Overhead stalls and underruns do not shift the frame: the interval between strobes stays FRAME_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| oh_ind_i | input | 1 | Overhead indicator from the framer; high stalls the next payload bit |
| src_data_i | input | BYTE_W | Payload byte from the source |
| src_valid_i | input | 1 | Source has a byte on `src_data_i` |
| src_ready_o | output | 1 | Block takes a byte at the next rising edge |
| ser_o | output | 1 | Serial payload bit |
| sof_o | output | 1 | One-cycle strobe on the first bit of each frame |
| underrun_o | output | 1 | Sticky flag: a fill bit was sent for lack of a byte |

## Verification
The bench runs a 30-cycle frame so that many frame boundaries fall inside each stimulus phase. The phases are: steady payload, random overhead stalls, bursts of consecutive stalls, a starving source, and a reset in the middle of a frame.

- A design that advanced the frame counter only on unstalled cycles would space its strobes more than FRAME_LEN apart during stall bursts.
- A design that consumed a bit during a stall would drop payload bits, so the bit sequence would no longer match the bench's model.
- A design that raised ready during a stall would take a byte early, or skip one.
- A design whose underrun flag was not sticky would clear it after the next valid byte.
- A design that used the wrong bit order would fail on the first byte.

// File: rtl/ds3src_pkg.sv
package ds3src_pkg;

   // Width of a counter that must hold the values 0 .. n-1 (at least one bit).
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Width of a counter that must hold the values 0 .. n.
   function automatic int unsigned fill_w(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ds3src_frame_timer.sv
module ds3src_frame_timer #(
   parameter int unsigned BLOCK_BITS     = 85,
   parameter int unsigned BLOCKS_PER_SUB = 8,
   parameter int unsigned SUBFRAMES      = 7,
   parameter bit          NESTED         = 1'b1
) (
   input  logic clk,
   input  logic rst,
   output logic sof_o
);
   import ds3src_pkg::*;

   localparam int unsigned FRAME_LEN = BLOCK_BITS * BLOCKS_PER_SUB * SUBFRAMES;

   logic at_start;

   if (BLOCK_BITS < 1 || BLOCKS_PER_SUB < 1 || SUBFRAMES < 1) begin : g_bad_dims
      $error("ds3src_frame_timer: frame dimensions must be at least 1");
   end

   if (NESTED) begin : g_nested
      localparam int unsigned BW = cnt_w(BLOCK_BITS);
      localparam int unsigned KW = cnt_w(BLOCKS_PER_SUB);
      localparam int unsigned SW = cnt_w(SUBFRAMES);
      logic [BW-1:0] bit_c;
      logic [KW-1:0] blk_c;
      logic [SW-1:0] sub_c;
      logic          bit_wrap;
      logic          blk_wrap;

      assign bit_wrap = (bit_c == BW'(BLOCK_BITS - 1));
      assign blk_wrap = (blk_c == KW'(BLOCKS_PER_SUB - 1));

      always_ff @(posedge clk) begin
         if (rst) begin
            bit_c <= '0;
            blk_c <= '0;
            sub_c <= '0;
         end else if (!bit_wrap) begin
            bit_c <= bit_c + 1'b1;
         end else begin
            bit_c <= '0;
            if (!blk_wrap) begin
               blk_c <= blk_c + 1'b1;
            end else begin
               blk_c <= '0;
               sub_c <= (sub_c == SW'(SUBFRAMES - 1)) ? '0 : sub_c + 1'b1;
            end
         end
      end

      assign at_start = (bit_c == '0) && (blk_c == '0) && (sub_c == '0);
   end else begin : g_flat
      localparam int unsigned PW = cnt_w(FRAME_LEN);
      logic [PW-1:0] pos;

      always_ff @(posedge clk) begin
         if (rst) begin
            pos <= '0;
         end else begin
            pos <= (pos == PW'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
         end
      end

      assign at_start = (pos == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sof_o <= 1'b0;
      end else begin
         sof_o <= at_start;
      end
   end

endmodule

// File: rtl/ds3src_payload_shifter.sv
module ds3src_payload_shifter #(
   parameter int unsigned BYTE_W   = 8,
   parameter bit          FILL_BIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stall_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              valid_i,
   output logic              ready_o,
   output logic              ser_o,
   output logic              underrun_o
);
   import ds3src_pkg::*;

   localparam int unsigned LW = fill_w(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_width
      $error("ds3src_payload_shifter: BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] shreg;
   logic [LW-1:0]     left;
   logic              empty;

   assign empty   = (left == '0);
   assign ready_o = !rst && !stall_i && empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg      <= '0;
         left       <= '0;
         ser_o      <= 1'b0;
         underrun_o <= 1'b0;
      end else if (!stall_i) begin
         if (!empty) begin
            ser_o <= shreg[BYTE_W-1];
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            left  <= left - 1'b1;
         end else if (valid_i) begin
            ser_o <= data_i[BYTE_W-1];
            shreg <= {data_i[BYTE_W-2:0], 1'b0};
            left  <= LW'(BYTE_W - 1);
         end else begin
            ser_o      <= FILL_BIT;
            underrun_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ds3_payload_source.sv
module ds3_payload_source #(
   parameter int unsigned BLOCK_BITS     = 85,
   parameter int unsigned BLOCKS_PER_SUB = 8,
   parameter int unsigned SUBFRAMES      = 7,
   parameter int unsigned BYTE_W         = 8,
   parameter bit          FILL_BIT       = 1'b0,
   parameter bit          NESTED         = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              oh_ind_i,
   input  logic [BYTE_W-1:0] src_data_i,
   input  logic              src_valid_i,
   output logic              src_ready_o,
   output logic              ser_o,
   output logic              sof_o,
   output logic              underrun_o
);

   localparam int unsigned FRAME_LEN = BLOCK_BITS * BLOCKS_PER_SUB * SUBFRAMES;

   ds3src_frame_timer #(
      .BLOCK_BITS    (BLOCK_BITS),
      .BLOCKS_PER_SUB(BLOCKS_PER_SUB),
      .SUBFRAMES     (SUBFRAMES),
      .NESTED        (NESTED)
   ) u_timer (
      .clk  (clk),
      .rst  (rst),
      .sof_o(sof_o)
   );

   ds3src_payload_shifter #(
      .BYTE_W  (BYTE_W),
      .FILL_BIT(FILL_BIT)
   ) u_shift (
      .clk       (clk),
      .rst       (rst),
      .stall_i   (oh_ind_i),
      .data_i    (src_data_i),
      .valid_i   (src_valid_i),
      .ready_o   (src_ready_o),
      .ser_o     (ser_o),
      .underrun_o(underrun_o)
   );

endmodule

// File: rtl/ds3_payload_source_chk.sv
module ds3_payload_source_chk #(
   parameter int unsigned FRAME_LEN = 4760,
   parameter bit          FILL_BIT  = 1'b0
) (
   input logic clk,
   input logic rst,
   input logic oh_ind_i,
   input logic src_valid_i,
   input logic src_ready_o,
   input logic ser_o,
   input logic sof_o,
   input logic underrun_o
);

   int unsigned gap;
   logic        seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (sof_o) begin
         gap  <= 1;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   always_comb begin
      if (rst) begin
         a_r1_reset_idle : assert (!src_ready_o);
      end
   end

   a_r2_first_sof : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |=> sof_o);

   a_r3_sof_spacing : assert property (@(posedge clk) disable iff (rst)
      seen |-> (sof_o == (gap == FRAME_LEN)));

   a_r3_sof_single : assert property (@(posedge clk) disable iff (rst)
      (sof_o && FRAME_LEN > 1) |=> !sof_o);

   a_r5_hold_on_oh : assert property (@(posedge clk) disable iff (rst)
      oh_ind_i |=> $stable(ser_o));

   a_r6_no_ready_on_oh : assert property (@(posedge clk) disable iff (rst)
      oh_ind_i |-> !src_ready_o);

   a_r7_fill_bit : assert property (@(posedge clk) disable iff (rst)
      (src_ready_o && !src_valid_i) |=> (ser_o == FILL_BIT) && underrun_o);

   a_r7_sticky : assert property (@(posedge clk) disable iff (rst)
      underrun_o |=> underrun_o);

endmodule

bind ds3_payload_source ds3_payload_source_chk #(
   .FRAME_LEN(FRAME_LEN),
   .FILL_BIT (FILL_BIT)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .oh_ind_i   (oh_ind_i),
   .src_valid_i(src_valid_i),
   .src_ready_o(src_ready_o),
   .ser_o      (ser_o),
   .sof_o      (sof_o),
   .underrun_o (underrun_o)
);

// File: tb/tb_ds3_payload_source.sv
module tb_ds3_payload_source;

   localparam int CLK_PERIOD = 10;
   localparam int BB = 5;
   localparam int BK = 2;
   localparam int SF = 3;
   localparam int LEN = BB * BK * SF;
   localparam bit FILL = 1'b1;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       oh_ind_i = 1'b0;
   logic [7:0] src_data_i = 8'h00;
   logic       src_valid_i = 1'b0;
   logic       src_ready_o, ser_o, sof_o, underrun_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   int         m_left = 0;
   logic [7:0] m_sh = 0;
   logic       m_ser = 0, m_sof = 0, m_under = 0;
   int         m_cnt = 0;
   int         byte_idx = 0;
   int         since_sof = 0;
   bit         sof_seen = 0;
   string      ser_tag = "R4";

   ds3_payload_source #(
      .BLOCK_BITS(BB), .BLOCKS_PER_SUB(BK), .SUBFRAMES(SF),
      .BYTE_W(8), .FILL_BIT(FILL), .NESTED(1'b1)
   ) dut (
      .clk(clk), .rst(rst), .oh_ind_i(oh_ind_i), .src_data_i(src_data_i),
      .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .ser_o(ser_o),
      .sof_o(sof_o), .underrun_o(underrun_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Drive one cycle of stimulus at a negedge, check ready, advance model, check outputs.
   task automatic step(input logic r, input logic oh, input logic v);
      logic exp_ready;
      rst         = r;
      oh_ind_i    = oh;
      src_valid_i = v;
      src_data_i  = 8'(byte_idx * 37 + 5);
      #1;
      exp_ready = !r && !oh && (m_left == 0);
      check(r ? "R1" : "R6", "src_ready_o", int'(src_ready_o), int'(exp_ready));
      if (r) begin
         m_left = 0; m_sh = 0; m_ser = 0; m_sof = 0; m_under = 0; m_cnt = 0;
         sof_seen = 0; ser_tag = "R1";
      end else begin
         m_sof = (m_cnt == 0);
         m_cnt = (m_cnt == LEN - 1) ? 0 : m_cnt + 1;
         if (oh) begin
            ser_tag = "R5";
         end else if (m_left > 0) begin
            m_ser = m_sh[7]; m_sh = m_sh << 1; m_left--; ser_tag = "R4";
         end else if (v) begin
            m_ser = src_data_i[7]; m_sh = src_data_i << 1; m_left = 7;
            byte_idx++; ser_tag = "R4";
         end else begin
            m_ser = FILL; m_under = 1; ser_tag = "R7";
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(ser_tag, "ser_o", int'(ser_o), int'(m_ser));
      check(r ? "R1" : "R3", "sof_o", int'(sof_o), int'(m_sof));
      check(r ? "R1" : "R7", "underrun_o", int'(underrun_o), int'(m_under));
      if (!r) begin
         since_sof++;
         if (sof_o) begin
            if (sof_seen) check("R8", "sof interval", since_sof, LEN);
            sof_seen = 1;
            since_sof = 0;
         end
      end
   endtask

   initial begin
      @(negedge clk);
      // R1: reset holds everything idle even with busy inputs
      for (int i = 0; i < 4; i++) step(1'b1, i[0], 1'b1);
      // R2: first strobe right after release, then low
      step(1'b0, 1'b0, 1'b1);
      check("R2", "first sof", int'(sof_o), 1);
      step(1'b0, 1'b0, 1'b1);
      check("R2", "sof after first", int'(sof_o), 0);
      // R4/R3: steady payload for several frames
      for (int i = 0; i < 4 * LEN; i++) step(1'b0, 1'b0, 1'b1);
      check("R7", "no underrun with steady source", int'(underrun_o), 0);
      // R5/R6/R8: random overhead stalls
      for (int i = 0; i < 6 * LEN; i++) step(1'b0, ($urandom % 4) == 0, 1'b1);
      // R5/R8: bursts of consecutive stalls
      for (int i = 0; i < 6 * LEN; i++) step(1'b0, (i % 11) < 3, 1'b1);
      check("R7", "no underrun before starving", int'(underrun_o), 0);
      // R7: starving source, then steady again (flag stays set)
      for (int i = 0; i < 4 * LEN; i++) step(1'b0, ($urandom % 5) == 0, ($urandom % 2) == 0);
      for (int i = 0; i < 2 * LEN; i++) step(1'b0, 1'b0, 1'b1);
      check("R7", "underrun sticky", int'(underrun_o), 1);
      // R1/R2: reset mid-frame clears flag and restarts frame
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
      check("R1", "underrun cleared", int'(underrun_o), 0);
      step(1'b0, 1'b1, 1'b1);
      check("R2", "sof after second reset", int'(sof_o), 1);
      for (int i = 0; i < 3 * LEN; i++) step(1'b0, (i % 7) == 0, (i % 13) != 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule